// File: doc/BRIEF.md
# Eight-Line Serial Receive Silo

This block is the receive half of an eight-line asynchronous serial multiplexer. Each line's bit-level receiver (outside this block) delivers an assembled character with a one-cycle valid strobe plus parity-error and framing-error indications. Every strobed character is latched in a one-deep holding slot for its line. A scanning state machine visits the lines in turn and moves each held character, tagged with its line number and error flags, into one shared first-in first-out silo.

A bus master sees two word addresses. Address 0 is the control/status word. Address 1 returns the oldest silo entry on a read and pops it. A write to address 1 instead loads the parameter set of one line. The stored parameters are also driven out to the line receivers. The receive interrupt follows the silo fill level, either on any entry or on an alarm level of sixteen entries.

The scanner has four states. `ST_CLEAR` is a one-cycle flush after a software clear. `ST_OFF` is idle while scanning is disabled. `ST_SCAN` examines one line per cycle. `ST_PUSH` writes the staged entry into the silo. The transitions are:
- Clear: any state goes to `ST_CLEAR` on a clear write.
- Clear done: `ST_CLEAR` goes to `ST_OFF`.
- Enable: `ST_OFF` goes to `ST_SCAN` once scan enable is set.
- Take: `ST_SCAN` goes to `ST_PUSH` when the examined line holds a character.
- Next: `ST_SCAN` stays in `ST_SCAN` and advances the pointer when that line is empty.
- Return: `ST_PUSH` goes back to `ST_SCAN`.
- Disable: `ST_SCAN` or `ST_PUSH` goes to `ST_OFF` when scan enable drops.

Top module: `mux_rx_silo`

## Requirements
- R1: A read of address 1 returns bit 15 set when the silo holds an entry. When the silo is empty it returns 0x0000, including right after the last entry was popped.
- R2: The receive word carries the character in bits 7:0, the line number in bits 10:8, the parity error in bit 12, the framing error in bit 13 and the overrun flag in bit 14. Bit 11 reads zero.
- R3: Entries leave the silo oldest first. Each read of address 1 pops one entry.
- R4: The control/status word (address 0) stores scan enable in bit 5, receive interrupt enable in bit 6, alarm enable in bit 12 and transmit interrupt enable in bit 14, and reads them back. Bit 7 reads 1 while the silo is non-empty. Writing bit 4 as 1 clears the silo, all four enables and every line's parameters, and the status word then reads 0x0000.
- R5: A write to address 1 stores wdata[11:3] as the parameter set of the line given by wdata[2:0]. The set appears on `line_cfg[9*n +: 9]`, and every line resets to 9'h003 (8-bit, parity off).
- R6: While scan enable is clear, strobed characters never reach the silo, and characters already held are discarded.
- R7: The silo holds 64 entries. When it is full, a character to be written is dropped, and the next entry that is written has its overrun bit set.
- R8: With alarm enable clear, `rx_irq` equals receive interrupt enable AND silo non-empty.
- R9: With alarm enable set, `rx_irq` rises only once at least 16 entries are held (and receive interrupt enable is set).
- R10: The line's length code (parameter bits 4:3) masks the stored character: 00 keeps 5 bits, 01 keeps 6, 10 keeps 7 and 11 keeps 8. Masked bits read zero.
- R11: A parity error is stored only if the line's parity-enable bit (parameter bit 6) is set. A framing error is always stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0 = control/status, 1 = receive word / line parameters |
| bus_rd | input | 1 | Read strobe; pops the silo when bus_addr is 1 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed word |
| line_stb | input | 8 | Per-line character valid strobe |
| line_data | input | 64 | Per-line character, 8 bits per line |
| line_perr | input | 8 | Per-line parity error with the strobe |
| line_ferr | input | 8 | Per-line framing error with the strobe |
| line_cfg | output | 72 | Per-line stored parameters, 9 bits per line |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The main path is driven by a table of six characters. The table mixes lines, all four length codes, parity enabled and disabled, and both error inputs. Each packed word therefore tells apart a wrong tag position, a wrong mask width and a parity flag that leaks through when parity is off. Two characters on different lines show oldest-first order. A strobe while scanning is off tells gating apart from merely delayed storage. A 65th character followed by a pop and a refill tells a dropped entry, and the overrun mark on the next entry, apart from a silo that overwrites. Counting up to fifteen and then sixteen entries separates the alarm threshold from the plain non-empty interrupt.

// File: rtl/mux_rx_pkg.sv
package mux_rx_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_OFF   = 2'd1,
        ST_SCAN  = 2'd2,
        ST_PUSH  = 2'd3
    } scan_state_e;

    typedef struct packed {
        logic       ovr;
        logic       ferr;
        logic       perr;
        logic [2:0] line;
        logic [7:0] data;
    } silo_entry_t;

    localparam int ENTRY_W = $bits(silo_entry_t);
    localparam int CFG_W   = 9;   // parameter word bits 11:3
    localparam logic [CFG_W-1:0] CFG_DEFAULT = 9'h003;

    // cfg bit positions (parameter word bit minus 3)
    localparam int CFG_LEN_LO = 0;
    localparam int CFG_PAR_EN = 3;

    function automatic logic [7:0] len_mask(input logic [7:0] d, input logic [1:0] len);
        logic [7:0] m;
        unique case (len)
            2'b00: m = 8'h1F;
            2'b01: m = 8'h3F;
            2'b10: m = 8'h7F;
            default: m = 8'hFF;
        endcase
        return d & m;
    endfunction

endpackage

// File: rtl/mux_rx_lpr.sv
module mux_rx_lpr
    import mux_rx_pkg::*;
#(
    parameter int NLINES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    wr,
    input  logic [15:0]             wdata,
    output logic [NLINES*CFG_W-1:0] cfg
);

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_line
            logic [CFG_W-1:0] cfg_q;
            always_ff @(posedge clk) begin
                if (!rst_n || flush) begin
                    cfg_q <= CFG_DEFAULT;
                end else if (wr && (wdata[2:0] == 3'(i))) begin
                    cfg_q <= wdata[11:3];
                end
            end
            assign cfg[i*CFG_W +: CFG_W] = cfg_q;
        end
    endgenerate

endmodule

// File: rtl/mux_rx_hold.sv
module mux_rx_hold
    import mux_rx_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    scan_en,
    input  logic [NLINES-1:0]       stb,
    input  logic [NLINES*8-1:0]     data,
    input  logic [NLINES-1:0]       perr,
    input  logic [NLINES-1:0]       ferr,
    input  logic [NLINES*CFG_W-1:0] cfg,
    input  logic [NLINES-1:0]       take,
    input  logic [LW-1:0]           sel,
    output logic [NLINES-1:0]       pend,
    output silo_entry_t             sel_ent
);

    logic [NLINES*ENTRY_W-1:0] ent_vec;

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_slot
            logic             p_q;
            logic [7:0]       d_q;
            logic             pe_q;
            logic             fe_q;
            logic             ov_q;
            logic [CFG_W-1:0] c;
            assign c = cfg[i*CFG_W +: CFG_W];

            always_ff @(posedge clk) begin
                if (!rst_n || flush || !scan_en) begin
                    p_q  <= 1'b0;
                    d_q  <= '0;
                    pe_q <= 1'b0;
                    fe_q <= 1'b0;
                    ov_q <= 1'b0;
                end else if (stb[i]) begin
                    p_q  <= 1'b1;
                    d_q  <= len_mask(data[i*8 +: 8], c[CFG_LEN_LO +: 2]);
                    pe_q <= perr[i] & c[CFG_PAR_EN];
                    fe_q <= ferr[i];
                    ov_q <= p_q & ~take[i];   // unsent character replaced
                end else if (take[i]) begin
                    p_q <= 1'b0;
                end
            end

            assign pend[i] = p_q;
            assign ent_vec[i*ENTRY_W +: ENTRY_W] = {ov_q, fe_q, pe_q, 3'(i), d_q};
        end
    endgenerate

    assign sel_ent = silo_entry_t'(ent_vec[sel*ENTRY_W +: ENTRY_W]);

endmodule

// File: rtl/mux_rx_fifo.sv
module mux_rx_fifo #(
    parameter int W     = 14,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    assign full    = (count == DEPTH_C);
    assign empty   = (count == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/mux_rx_scan.sv
module mux_rx_scan
    import mux_rx_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              mse,
    input  logic [NLINES-1:0] pend,
    input  logic              full,
    input  silo_entry_t       sel_ent,
    output scan_state_e       state,
    output logic [LW-1:0]     sel,
    output logic [NLINES-1:0] take,
    output logic              push,
    output silo_entry_t       push_ent
);

    localparam logic [LW-1:0] LAST = LW'(NLINES - 1);

    scan_state_e st_q;
    scan_state_e st_d;
    logic [LW-1:0] ptr_q;
    silo_entry_t   stage_q;
    logic          lost_q;
    logic          drop;
    logic          taking;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CLEAR: st_d = ST_OFF;
            ST_OFF:   if (mse) st_d = ST_SCAN;
            ST_SCAN: begin
                if (!mse)            st_d = ST_OFF;
                else if (pend[ptr_q]) st_d = ST_PUSH;
            end
            ST_PUSH:  st_d = mse ? ST_SCAN : ST_OFF;
            default:  st_d = ST_OFF;
        endcase
        if (soft_clr) st_d = ST_CLEAR;
    end

    // outputs
    always_comb begin
        taking = (st_q == ST_SCAN) && mse && pend[ptr_q];
        take   = '0;
        if (taking) take[ptr_q] = 1'b1;
        push   = (st_q == ST_PUSH) && mse && !full;
        drop   = (st_q == ST_PUSH) && mse && full;
        push_ent     = stage_q;
        push_ent.ovr = stage_q.ovr | lost_q;
    end

    // scan pointer, staging entry and lost-character flag
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            ptr_q   <= '0;
            stage_q <= '0;
            lost_q  <= 1'b0;
        end else begin
            if (st_q == ST_OFF || st_q == ST_CLEAR) begin
                ptr_q <= '0;
            end else if ((st_q == ST_SCAN && !taking) || st_q == ST_PUSH) begin
                ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
            end
            if (taking) stage_q <= sel_ent;
            if (drop)       lost_q <= 1'b1;
            else if (push)  lost_q <= 1'b0;
        end
    end

    assign state = st_q;
    assign sel   = ptr_q;

endmodule

// File: rtl/mux_rx_silo.sv
module mux_rx_silo
    import mux_rx_pkg::*;
#(
    parameter int NLINES    = 8,
    parameter int DEPTH     = 64,
    parameter int ALARM_LVL = 16,
    localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_addr,
    input  logic                    bus_rd,
    input  logic                    bus_wr,
    input  logic [15:0]             bus_wdata,
    output logic [15:0]             bus_rdata,
    input  logic [NLINES-1:0]       line_stb,
    input  logic [NLINES*8-1:0]     line_data,
    input  logic [NLINES-1:0]       line_perr,
    input  logic [NLINES-1:0]       line_ferr,
    output logic [NLINES*CFG_W-1:0] line_cfg,
    output logic                    rx_irq
);

    localparam logic [CW-1:0] ALARM_C = CW'(ALARM_LVL);

    logic csr_mse, csr_rie, csr_sae, csr_tie;
    logic soft_clr;
    logic csr_wr, lpr_wr, rbuf_rd;

    logic [NLINES-1:0] pend;
    logic [NLINES-1:0] take;
    logic [LW-1:0]     sel;
    silo_entry_t       sel_ent;
    silo_entry_t       push_ent;
    silo_entry_t       head;
    logic              push;
    scan_state_e       state;
    logic [CW-1:0]     silo_count;
    logic              silo_full, silo_empty;

    assign csr_wr   = bus_wr & ~bus_addr;
    assign lpr_wr   = bus_wr &  bus_addr;
    assign rbuf_rd  = bus_rd &  bus_addr;
    assign soft_clr = csr_wr & bus_wdata[4];

    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            csr_mse <= 1'b0;
            csr_rie <= 1'b0;
            csr_sae <= 1'b0;
            csr_tie <= 1'b0;
        end else if (csr_wr) begin
            csr_mse <= bus_wdata[5];
            csr_rie <= bus_wdata[6];
            csr_sae <= bus_wdata[12];
            csr_tie <= bus_wdata[14];
        end
    end

    mux_rx_lpr #(.NLINES(NLINES)) u_lpr (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (soft_clr),
        .wr    (lpr_wr),
        .wdata (bus_wdata),
        .cfg   (line_cfg)
    );

    mux_rx_hold #(.NLINES(NLINES)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (soft_clr),
        .scan_en (csr_mse),
        .stb     (line_stb),
        .data    (line_data),
        .perr    (line_perr),
        .ferr    (line_ferr),
        .cfg     (line_cfg),
        .take    (take),
        .sel     (sel),
        .pend    (pend),
        .sel_ent (sel_ent)
    );

    mux_rx_scan #(.NLINES(NLINES)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .mse      (csr_mse),
        .pend     (pend),
        .full     (silo_full),
        .sel_ent  (sel_ent),
        .state    (state),
        .sel      (sel),
        .take     (take),
        .push     (push),
        .push_ent (push_ent)
    );

    mux_rx_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (soft_clr),
        .push  (push),
        .din   (push_ent),
        .pop   (rbuf_rd),
        .dout  (head),
        .count (silo_count),
        .full  (silo_full),
        .empty (silo_empty)
    );

    always_comb begin
        if (bus_addr) begin
            if (silo_empty) bus_rdata = 16'h0000;
            else bus_rdata = {1'b1, head.ovr, head.ferr, head.perr, 1'b0, head.line, head.data};
        end else begin
            bus_rdata = {1'b0, csr_tie, 1'b0, csr_sae, 4'b0000,
                         ~silo_empty, csr_rie, csr_mse, (state == ST_CLEAR), 4'b0000};
        end
    end

    assign rx_irq = csr_rie & (csr_sae ? (silo_count >= ALARM_C) : ~silo_empty);

endmodule

// File: rtl/mux_rx_silo_chk.sv
module mux_rx_silo_chk #(
    parameter int DEPTH     = 64,
    parameter int ALARM_LVL = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_addr,
    input logic          bus_wr,
    input logic [15:0]   bus_wdata,
    input logic [15:0]   bus_rdata,
    input logic          rx_irq,
    input logic [CW-1:0] count,
    input logic          mse,
    input logic          rie,
    input logic          sae
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] ALARM_C = CW'(ALARM_LVL);

    a_r1_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr && count == '0) |-> (bus_rdata == 16'h0000));

    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[4]) |=> (count == '0 && !mse && !rie && !rx_irq));

    a_r6_no_fill_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mse |=> (count <= $past(count)));

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C);

    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !rie |-> !rx_irq);

    a_r9_alarm_holds_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (sae && count < ALARM_C) |-> !rx_irq);

endmodule

bind mux_rx_silo mux_rx_silo_chk #(.DEPTH(DEPTH), .ALARM_LVL(ALARM_LVL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rx_irq    (rx_irq),
    .count     (silo_count),
    .mse       (csr_mse),
    .rie       (csr_rie),
    .sae       (csr_sae)
);

// File: tb/test_mux_rx_silo.sv
`timescale 1ns/1ps
module test_mux_rx_silo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_addr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  line_stb = '0;
    logic [63:0] line_data = '0;
    logic [7:0]  line_perr = '0;
    logic [7:0]  line_ferr = '0;
    logic [71:0] line_cfg;
    logic        rx_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mux_rx_silo i_mux_rx_silo (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_stb(line_stb), .line_data(line_data),
        .line_perr(line_perr), .line_ferr(line_ferr),
        .line_cfg(line_cfg), .rx_irq(rx_irq)
    );

    // {param word, line, data, perr, ferr, expected receive word}
    localparam logic [44:0] VEC [6] = '{
        {16'h0018, 3'd0, 8'hA5, 1'b1, 1'b0, 16'h80A5},
        {16'h0253, 3'd3, 8'hFF, 1'b1, 1'b0, 16'h937F},
        {16'h0005, 3'd5, 8'hFF, 1'b0, 1'b1, 16'hA51F},
        {16'h00CF, 3'd7, 8'hC3, 1'b1, 1'b1, 16'hB703},
        {16'h0039, 3'd1, 8'h80, 1'b0, 1'b0, 16'h8180},
        {16'h0F56, 3'd6, 8'h80, 1'b0, 1'b0, 16'h8600}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic strobe(input int ln, input logic [7:0] d, input logic pe, input logic fe);
        @(negedge clk);
        line_stb[ln] = 1'b1;
        line_data[ln*8 +: 8] = d;
        line_perr[ln] = pe;
        line_ferr[ln] = fe;
        @(negedge clk);
        line_stb = '0; line_perr = '0; line_ferr = '0;
        repeat (12) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state: R1, R4, R5
        bus_read(1'b0, rd); check("R4 reset csr", rd, 16'h0000);
        bus_read(1'b1, rd); check("R1 reset empty word", rd, 16'h0000);
        check("R8 reset irq", {15'd0, rx_irq}, 16'h0000);
        for (int n = 0; n < 8; n++)
            check("R5 reset cfg", {7'd0, line_cfg[n*9 +: 9]}, 16'h0003);

        // table walk: R2, R5, R10, R11
        bus_write(1'b0, 16'h0060);
        for (int v = 0; v < 6; v++) begin
            logic [44:0] e;
            e = VEC[v];
            bus_write(1'b1, e[44:29]);
            check("R5 cfg store", {7'd0, line_cfg[int'(e[28:26])*9 +: 9]}, {7'd0, e[40:32]});
            strobe(int'(e[28:26]), e[25:18], e[17], e[16]);
            bus_read(1'b1, rd); check("R2 R10 R11 word", rd, e[15:0]);
            bus_read(1'b1, rd); check("R1 empty after pop", rd, 16'h0000);
        end

        // R8 interrupt, R4 status bit 7, R3 order
        check("R8 irq idle", {15'd0, rx_irq}, 16'h0000);
        strobe(2, 8'h11, 1'b0, 1'b0);
        check("R8 irq on data", {15'd0, rx_irq}, 16'h0001);
        bus_read(1'b0, rd); check("R4 csr nonempty", rd, 16'h00E0);
        strobe(4, 8'h22, 1'b0, 1'b0);
        bus_read(1'b1, rd); check("R3 first out", rd, 16'h8211);
        bus_read(1'b1, rd); check("R3 second out", rd, 16'h8422);
        check("R8 irq drained", {15'd0, rx_irq}, 16'h0000);

        // R6 scan gating
        bus_write(1'b0, 16'h0040);
        strobe(2, 8'h33, 1'b0, 1'b0);
        bus_read(1'b1, rd); check("R6 gated word", rd, 16'h0000);
        check("R6 gated irq", {15'd0, rx_irq}, 16'h0000);
        bus_write(1'b0, 16'h0060);
        repeat (12) @(negedge clk);
        bus_read(1'b1, rd); check("R6 held char discarded", rd, 16'h0000);

        // R4 readback
        bus_write(1'b0, 16'h5060);
        bus_read(1'b0, rd); check("R4 csr readback", rd, 16'h5060);

        // R9 alarm and R7 overflow
        for (int k = 0; k < 15; k++) strobe(2, 8'(k), 1'b0, 1'b0);
        check("R9 below alarm", {15'd0, rx_irq}, 16'h0000);
        strobe(2, 8'd15, 1'b0, 1'b0);
        check("R9 at alarm", {15'd0, rx_irq}, 16'h0001);
        for (int k = 16; k < 64; k++) strobe(2, 8'(k), 1'b0, 1'b0);
        strobe(2, 8'hEE, 1'b0, 1'b0);              // dropped, silo full
        bus_read(1'b1, rd); check("R7 oldest kept", rd, 16'h8200);
        strobe(2, 8'h77, 1'b0, 1'b0);
        for (int k = 1; k < 64; k++) begin
            bus_read(1'b1, rd);
            check("R7 R3 drain order", rd, 16'h8200 | 16'(k));
        end
        bus_read(1'b1, rd); check("R7 overrun marked", rd, 16'hC277);
        bus_read(1'b1, rd); check("R7 dropped not stored", rd, 16'h0000);

        // R4 clear
        bus_write(1'b1, 16'h0253);
        strobe(2, 8'h44, 1'b0, 1'b0);
        bus_write(1'b0, 16'h0070);
        repeat (2) @(negedge clk);
        bus_read(1'b0, rd); check("R4 csr after clear", rd, 16'h0000);
        bus_read(1'b1, rd); check("R4 silo after clear", rd, 16'h0000);
        check("R4 irq after clear", {15'd0, rx_irq}, 16'h0000);
        check("R4 cfg after clear", {7'd0, line_cfg[3*9 +: 9]}, 16'h0003);

        finish_run();
    end

endmodule